// File: doc/BRIEF.md
# Operand Addressing Decoder

This block sits at the front of an instruction pipeline. It takes the instruction byte stream one byte per accepted handshake. It classifies the leading opcode byte and pulls in whatever address bytes the encoding calls for. From that it produces one operand description. The operand is either a register, a source memory operand or a target memory operand. For memory operands the result also carries an operand size and a 32-bit effective address. Leading bytes that are not operand selectors are still classified and reported: no-operation, carry complement, software interrupt with its number, undefined, or other.

Pointer values come through a combinational register-read port. The port is addressed by an 8-bit byte-granular register code, and multi-byte reads are little-endian. The auto-decrement and auto-increment modes return the updated pointer through a single-cycle, 32-bit register-write port. The second opcode byte and the memory data accesses belong to the next stage.

A result is held on the result port until the consumer acknowledges it. No new byte is taken while a result is pending.

Top module: `am_operand_decoder`

## Requirements
- R1: A byte is consumed on each rising edge with `in_valid` and `in_ready` both high. `res_valid` rises in the cycle after the last byte of an instruction. All result fields then hold until a cycle with `res_ack` high, after which `res_valid` is low. `in_ready` is low whenever `res_valid` is high. After reset, `in_ready`=1, `res_valid`=0 and `wr_en`=0.
- R2: Result encodings:
  - `res_kind`: 0 other, 1 no-op, 2 carry complement, 3 undefined, 4 software interrupt, 5 register, 6 source memory, 7 target memory.
  - `res_size`: 0 byte, 1 word, 2 long, 3 none.
  - Fields that do not apply to a kind read as zero. `res_size` is 3 for kinds 0 to 4.
- R3: Leading bytes 0x80–0xBF use bits [5:4] as the group: 0, 1 and 2 give source memory of byte, word and long size; 3 gives target memory of size none. The pointer is the 32-bit register at code 0xE0+4·bits[2:0]. With bit 3 set, the next byte is added as a signed 8-bit displacement.
- R4: In the groups 0xC0, 0xD0, 0xE0 and 0xF0, a low nibble of 0, 1 or 2 fetches a 1-, 2- or 3-byte absolute address. The address is least significant byte first and zero-extended. The groups give byte, word and long source memory, and target memory, in that order.
- R5: Low nibble 3 fetches a mode byte M. The pointer is the long register at M&0xFC. M[1:0] selects the offset:
  - 0: no offset.
  - 1: adds a signed 16-bit displacement from the next two bytes, LSB first.
  - 2: adds the sign-extended byte register whose code is the next byte.
  - 3: adds the sign-extended word register at code (next byte)&0xFE.
- R6: Low nibble 4 with mode byte M subtracts a step of 1, 2, 4 or 0 from the pointer at M&0xFC, for M[1:0] = 0, 1, 2 or 3. The decremented value is the address. When the step is nonzero, `wr_en` pulses for exactly the first `res_valid` cycle, with that pointer code and the new value.
- R7: Low nibble 5 works like R6, but the address is the pointer before the update and the pointer is incremented by the step.
- R8: Leading bytes 0xC7, 0xD7 and 0xE7 produce a register operand of size byte, word or long. Its code is the next byte, masked with 0xFE for word and 0xFC for long.
- R9: Leading bytes 0xC8–0xCF select, by bits [2:0] = 0..7, the byte registers 0xE1, 0xE0, 0xE5, 0xE4, 0xE9, 0xE8, 0xED and 0xEC. Bytes 0xD8–0xDF and 0xE8–0xEF select 0xE0+4·bits[2:0] as word and long registers respectively.
- R10: 0xF8–0xFF give a software interrupt whose number is bits [2:0] on `res_vec`.
- R11: The following bytes are single-byte instructions: 0x00 is no-op; 0x12 is carry complement; 0x04, 0x1F, 0xC6, 0xD6, 0xE6, 0xF6 and 0xF7 are undefined. Every other byte below 0x80 is kind other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction byte offered |
| in_data | input | 8 | Instruction byte |
| in_ready | output | 1 | Byte can be consumed this cycle |
| rd_en | output | 1 | Register read in use this cycle |
| rd_code | output | 8 | Register code to read |
| rd_size | output | 2 | Read size (0 byte, 1 word, 2 long) |
| rd_data | input | 32 | Register value, combinational, zero-extended |
| wr_en | output | 1 | Pointer writeback strobe |
| wr_code | output | 8 | Pointer code to write (long) |
| wr_data | output | 32 | Updated pointer value |
| res_valid | output | 1 | Decoded result pending |
| res_ack | input | 1 | Consumer takes the result |
| res_kind | output | 3 | Result kind |
| res_size | output | 2 | Operand size |
| res_reg | output | 8 | Register operand code |
| res_vec | output | 3 | Software interrupt number |
| res_addr | output | 32 | Effective address |

## Verification
The hardest situation to reach from the ports is a pointer update that wraps or does nothing. Examples are an increment of an all-ones pointer, and the fourth step selector, which gives neither a write nor a change of address. A purely random byte stream rarely lands on these, so the bench first loads chosen pointer values into its own register-file model and then plays directed sequences. Random traffic of several hundred instructions follows. It is biased toward the operand-selecting half of the opcode space, with idle gaps between bytes and junk bytes offered while a result waits, so that the hold and back-pressure rules are exercised in every encoding length.

// File: rtl/am_pkg.sv
package am_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    K_OTHER = 3'd0,
    K_NOP   = 3'd1,
    K_CCF   = 3'd2,
    K_UNDEF = 3'd3,
    K_SWI   = 3'd4,
    K_REG   = 3'd5,
    K_SRC   = 3'd6,
    K_DST   = 3'd7
  } kind_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_NONE = 2'd3
  } size_e;

  typedef enum logic [2:0] {
    NX_NONE    = 3'd0,
    NX_DISP8   = 3'd1,
    NX_ABS     = 3'd2,
    NX_MODE    = 3'd3,
    NX_REGCODE = 3'd4
  } next_e;

  typedef enum logic [1:0] {
    MO_EXT     = 2'd0,
    MO_PREDEC  = 2'd1,
    MO_POSTINC = 2'd2
  } mode_op_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_MODE = 3'd1,
    S_IMM  = 3'd2,
    S_IDX  = 3'd3,
    S_REGC = 3'd4,
    S_DONE = 3'd5
  } state_e;

  typedef struct packed {
    kind_e       kind;
    size_e       size;
    next_e       nxt;
    logic [1:0]  abs_len;
    mode_op_e    mop;
    logic        ind_ptr;
    logic [7:0]  reg_code;
    logic [2:0]  vec;
  } class_t;

endpackage

// File: rtl/am_rst_sync.sv
module am_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/am_first_byte_class.sv
module am_first_byte_class
  import am_pkg::*;
#(
  parameter logic [7:0] BANK_BASE = 8'hE0
) (
  input  logic [7:0] op_byte,
  output class_t     cls
);
  logic [1:0] grp;
  logic [2:0] idx;

  assign grp = op_byte[5:4];
  assign idx = op_byte[2:0];

  always_comb begin
    cls          = '0;
    cls.kind     = K_OTHER;
    cls.size     = SZ_NONE;
    cls.nxt      = NX_NONE;
    cls.mop      = MO_EXT;
    if (op_byte == 8'h00) begin
      cls.kind = K_NOP;
    end else if (op_byte == 8'h12) begin
      cls.kind = K_CCF;
    end else if (op_byte == 8'h04 || op_byte == 8'h1F) begin
      cls.kind = K_UNDEF;
    end else if (op_byte[7:6] == 2'b10) begin
      // register-indirect, optional signed 8-bit displacement
      cls.kind    = (grp == 2'd3) ? K_DST : K_SRC;
      cls.size    = size_e'(grp);
      cls.ind_ptr = 1'b1;
      cls.nxt     = op_byte[3] ? NX_DISP8 : NX_NONE;
    end else if (op_byte[7:6] == 2'b11) begin
      if (grp == 2'd3 && op_byte[3]) begin
        cls.kind = K_SWI;
        cls.vec  = idx;
      end else if (op_byte[3]) begin
        cls.kind = K_REG;
        cls.size = size_e'(grp);
        if (grp == 2'd0)
          cls.reg_code = BANK_BASE + {4'b0000, idx[2:1], 2'b00} + {7'b0, ~idx[0]};
        else
          cls.reg_code = BANK_BASE + {3'b000, idx, 2'b00};
      end else begin
        cls.kind = (grp == 2'd3) ? K_DST : K_SRC;
        cls.size = size_e'(grp);
        case (idx)
          3'd0, 3'd1, 3'd2: begin
            cls.nxt     = NX_ABS;
            cls.abs_len = idx[1:0] + 2'd1;
          end
          3'd3: begin
            cls.nxt = NX_MODE;
            cls.mop = MO_EXT;
          end
          3'd4: begin
            cls.nxt = NX_MODE;
            cls.mop = MO_PREDEC;
          end
          3'd5: begin
            cls.nxt = NX_MODE;
            cls.mop = MO_POSTINC;
          end
          3'd6: begin
            cls.kind = K_UNDEF;
            cls.size = SZ_NONE;
          end
          default: begin
            if (grp == 2'd3) begin
              cls.kind = K_UNDEF;
              cls.size = SZ_NONE;
            end else begin
              cls.kind = K_REG;
              cls.nxt  = NX_REGCODE;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/am_imm_assemble.sv
module am_imm_assemble #(
  parameter int MAX_BYTES = 3,
  parameter int OUT_W     = 32,
  localparam int ACC_W    = MAX_BYTES * 8,
  localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic [ACC_W-1:0] acc_q,
  input  logic [7:0]       new_byte,
  input  logic [CNT_W-1:0] pos,
  input  logic [CNT_W-1:0] len,
  input  logic             sgn,
  output logic [ACC_W-1:0] acc_merged,
  output logic [OUT_W-1:0] value_ext
);
  logic [7:0] lane [MAX_BYTES];

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_lane
    assign lane[g] = (pos == CNT_W'(g)) ? new_byte : acc_q[g*8 +: 8];
    assign acc_merged[g*8 +: 8] = lane[g];
  end

  logic msb;
  always_comb begin
    msb = 1'b0;
    for (int g = 0; g < MAX_BYTES; g++) begin
      if (CNT_W'(g + 1) == len) msb = lane[g][7];
    end
  end

  always_comb begin
    value_ext = {OUT_W{sgn & msb}};
    for (int g = 0; g < MAX_BYTES; g++) begin
      if (CNT_W'(g) < len) value_ext[g*8 +: 8] = lane[g];
    end
  end
endmodule

// File: rtl/am_ptr_step.sv
module am_ptr_step #(
  parameter int AW = 32
) (
  input  logic [1:0]    sel,
  input  logic [AW-1:0] ptr,
  output logic [AW-1:0] ptr_dec,
  output logic [AW-1:0] ptr_inc,
  output logic          step_nz
);
  logic [AW-1:0] step;

  always_comb begin
    case (sel)
      2'd0:    step = AW'(1);
      2'd1:    step = AW'(2);
      2'd2:    step = AW'(4);
      default: step = '0;
    endcase
  end

  assign ptr_dec = ptr - step;
  assign ptr_inc = ptr + step;
  assign step_nz = (sel != 2'd3);
endmodule

// File: rtl/am_operand_decoder.sv
module am_operand_decoder
  import am_pkg::*;
#(
  parameter int         ADDR_W    = 32,
  parameter int         CODE_W    = 8,
  parameter int         IMM_BYTES = 3,
  parameter logic [7:0] BANK_BASE = 8'hE0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              rd_en,
  output logic [CODE_W-1:0] rd_code,
  output logic [1:0]        rd_size,
  input  logic [ADDR_W-1:0] rd_data,
  output logic              wr_en,
  output logic [CODE_W-1:0] wr_code,
  output logic [ADDR_W-1:0] wr_data,
  output logic              res_valid,
  input  logic              res_ack,
  output logic [2:0]        res_kind,
  output logic [1:0]        res_size,
  output logic [CODE_W-1:0] res_reg,
  output logic [2:0]        res_vec,
  output logic [ADDR_W-1:0] res_addr
);
  localparam int ACC_W = IMM_BYTES * BYTE_W;
  localparam int CNT_W = $clog2(IMM_BYTES + 1);

  logic rst_sync_n;
  am_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  // state
  state_e             state_q, state_d;
  kind_e              kind_q, kind_d;
  size_e              size_q, size_d;
  logic [CODE_W-1:0]  reg_q, reg_d;
  logic [2:0]         vec_q, vec_d;
  logic [ADDR_W-1:0]  base_q, base_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [ACC_W-1:0]   acc_q, acc_d;
  logic [CNT_W-1:0]   pos_q, pos_d;
  logic [CNT_W-1:0]   len_q, len_d;
  logic               sgn_q, sgn_d;
  mode_op_e           mop_q, mop_d;
  logic               idxw_q, idxw_d;
  logic               wr_en_q, wr_en_d;
  logic [CODE_W-1:0]  wr_code_q, wr_code_d;
  logic [ADDR_W-1:0]  wr_data_q, wr_data_d;

  logic accept;
  assign accept = in_valid && rst_sync_n && (state_q != S_DONE);

  // leading-byte classification
  class_t cls;
  am_first_byte_class #(.BANK_BASE(BANK_BASE)) u_class (
    .op_byte(in_data), .cls(cls)
  );

  // pointer step for auto-modify forms
  logic [ADDR_W-1:0] ptr_dec, ptr_inc;
  logic              step_nz;
  am_ptr_step #(.AW(ADDR_W)) u_step (
    .sel(in_data[1:0]), .ptr(rd_data),
    .ptr_dec(ptr_dec), .ptr_inc(ptr_inc), .step_nz(step_nz)
  );

  // immediate assembly
  logic [ACC_W-1:0]  acc_merged;
  logic [ADDR_W-1:0] imm_ext;
  am_imm_assemble #(.MAX_BYTES(IMM_BYTES), .OUT_W(ADDR_W)) u_imm (
    .acc_q(acc_q), .new_byte(in_data), .pos(pos_q), .len(len_q),
    .sgn(sgn_q), .acc_merged(acc_merged), .value_ext(imm_ext)
  );

  // register-read port steering
  always_comb begin
    rd_en   = 1'b0;
    rd_code = '0;
    rd_size = SZ_LONG;
    case (state_q)
      S_IDLE: begin
        rd_en   = in_valid && cls.ind_ptr;
        rd_code = BANK_BASE + {3'b000, in_data[2:0], 2'b00};
        rd_size = SZ_LONG;
      end
      S_MODE: begin
        rd_en   = in_valid;
        rd_code = in_data & 8'hFC;
        rd_size = SZ_LONG;
      end
      S_IDX: begin
        rd_en   = in_valid;
        rd_code = idxw_q ? (in_data & 8'hFE) : in_data;
        rd_size = idxw_q ? SZ_WORD : SZ_BYTE;
      end
      default: ;
    endcase
  end

  logic [ADDR_W-1:0] idx_sext;
  assign idx_sext = idxw_q ? {{(ADDR_W-16){rd_data[15]}}, rd_data[15:0]}
                           : {{(ADDR_W-8){rd_data[7]}}, rd_data[7:0]};

  // next-state logic
  always_comb begin
    state_d   = state_q;
    kind_d    = kind_q;
    size_d    = size_q;
    reg_d     = reg_q;
    vec_d     = vec_q;
    base_d    = base_q;
    addr_d    = addr_q;
    acc_d     = acc_q;
    pos_d     = pos_q;
    len_d     = len_q;
    sgn_d     = sgn_q;
    mop_d     = mop_q;
    idxw_d    = idxw_q;
    wr_en_d   = 1'b0;
    wr_code_d = wr_code_q;
    wr_data_d = wr_data_q;

    case (state_q)
      S_IDLE: if (accept) begin
        kind_d = cls.kind;
        size_d = cls.size;
        reg_d  = cls.reg_code;
        vec_d  = cls.vec;
        addr_d = '0;
        acc_d  = '0;
        pos_d  = '0;
        mop_d  = cls.mop;
        case (cls.nxt)
          NX_DISP8: begin
            base_d  = rd_data;
            len_d   = CNT_W'(1);
            sgn_d   = 1'b1;
            state_d = S_IMM;
          end
          NX_ABS: begin
            base_d  = '0;
            len_d   = CNT_W'(cls.abs_len);
            sgn_d   = 1'b0;
            state_d = S_IMM;
          end
          NX_MODE:    state_d = S_MODE;
          NX_REGCODE: state_d = S_REGC;
          default: begin
            addr_d  = cls.ind_ptr ? rd_data : '0;
            state_d = S_DONE;
          end
        endcase
      end

      S_MODE: if (accept) begin
        base_d = rd_data;
        case (mop_q)
          MO_PREDEC: begin
            addr_d    = ptr_dec;
            wr_en_d   = step_nz;
            wr_code_d = in_data & 8'hFC;
            wr_data_d = ptr_dec;
            state_d   = S_DONE;
          end
          MO_POSTINC: begin
            addr_d    = rd_data;
            wr_en_d   = step_nz;
            wr_code_d = in_data & 8'hFC;
            wr_data_d = ptr_inc;
            state_d   = S_DONE;
          end
          default: begin
            case (in_data[1:0])
              2'd0: begin
                addr_d  = rd_data;
                state_d = S_DONE;
              end
              2'd1: begin
                len_d   = CNT_W'(2);
                sgn_d   = 1'b1;
                pos_d   = '0;
                state_d = S_IMM;
              end
              2'd2: begin
                idxw_d  = 1'b0;
                state_d = S_IDX;
              end
              default: begin
                idxw_d  = 1'b1;
                state_d = S_IDX;
              end
            endcase
          end
        endcase
      end

      S_IMM: if (accept) begin
        acc_d = acc_merged;
        pos_d = pos_q + CNT_W'(1);
        if (pos_q == len_q - CNT_W'(1)) begin
          addr_d  = base_q + imm_ext;
          state_d = S_DONE;
        end
      end

      S_IDX: if (accept) begin
        addr_d  = base_q + idx_sext;
        state_d = S_DONE;
      end

      S_REGC: if (accept) begin
        case (size_q)
          SZ_LONG: reg_d = in_data & 8'hFC;
          SZ_WORD: reg_d = in_data & 8'hFE;
          default: reg_d = in_data;
        endcase
        state_d = S_DONE;
      end

      S_DONE: if (res_ack) state_d = S_IDLE;

      default: state_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q   <= S_IDLE;
      kind_q    <= K_OTHER;
      size_q    <= SZ_NONE;
      reg_q     <= '0;
      vec_q     <= '0;
      base_q    <= '0;
      addr_q    <= '0;
      acc_q     <= '0;
      pos_q     <= '0;
      len_q     <= '0;
      sgn_q     <= 1'b0;
      mop_q     <= MO_EXT;
      idxw_q    <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_code_q <= '0;
      wr_data_q <= '0;
    end else begin
      state_q   <= state_d;
      kind_q    <= kind_d;
      size_q    <= size_d;
      reg_q     <= reg_d;
      vec_q     <= vec_d;
      base_q    <= base_d;
      addr_q    <= addr_d;
      acc_q     <= acc_d;
      pos_q     <= pos_d;
      len_q     <= len_d;
      sgn_q     <= sgn_d;
      mop_q     <= mop_d;
      idxw_q    <= idxw_d;
      wr_en_q   <= wr_en_d;
      wr_code_q <= wr_code_d;
      wr_data_q <= wr_data_d;
    end
  end

  assign in_ready  = rst_sync_n && (state_q != S_DONE);
  assign res_valid = (state_q == S_DONE);
  assign res_kind  = kind_q;
  assign res_size  = size_q;
  assign res_reg   = reg_q;
  assign res_vec   = vec_q;
  assign res_addr  = addr_q;
  assign wr_en     = wr_en_q;
  assign wr_code   = wr_code_q;
  assign wr_data   = wr_data_q;
endmodule

// File: rtl/am_operand_decoder_chk.sv
module am_operand_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        wr_en,
  input logic [7:0]  wr_code,
  input logic        res_valid,
  input logic        res_ack,
  input logic [2:0]  res_kind,
  input logic [1:0]  res_size,
  input logic [7:0]  res_reg,
  input logic [31:0] res_addr
);
  // R1: result held until acknowledged
  p_hold_result_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ack) |=> (res_valid && $stable(res_addr) &&
                                 $stable(res_kind) && $stable(res_reg)));

  // R1: no byte accepted while a result is pending
  p_no_ready_pending_r1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !in_ready);

  // R6: writeback is a single-cycle pulse
  p_wr_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R7: writeback only alongside a fresh result, to a long-aligned code
  p_wr_with_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (res_valid && wr_code[1:0] == 2'b00 && $rose(res_valid)));

  // R8: long register operands are long-aligned
  p_long_reg_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind == 3'd5 && res_size == 2'd2) |-> res_reg[1:0] == 2'b00);

  // R10: software interrupts carry no size and no address
  p_swi_unsized_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind == 3'd4) |-> (res_size == 2'd3 && res_addr == 32'd0));
endmodule

bind am_operand_decoder am_operand_decoder_chk u_chk (.*);

// File: tb/am_operand_decoder_bench.sv
module am_operand_decoder_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready;
  logic [7:0]  in_data;
  logic        rd_en;
  logic [7:0]  rd_code;
  logic [1:0]  rd_size;
  logic [31:0] rd_data;
  logic        wr_en;
  logic [7:0]  wr_code;
  logic [31:0] wr_data;
  logic        res_valid, res_ack;
  logic [2:0]  res_kind;
  logic [1:0]  res_size;
  logic [7:0]  res_reg;
  logic [2:0]  res_vec;
  logic [31:0] res_addr;

  int n_run  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  am_operand_decoder u_am_operand_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .rd_en(rd_en), .rd_code(rd_code), .rd_size(rd_size),
    .rd_data(rd_data), .wr_en(wr_en), .wr_code(wr_code), .wr_data(wr_data),
    .res_valid(res_valid), .res_ack(res_ack), .res_kind(res_kind),
    .res_size(res_size), .res_reg(res_reg), .res_vec(res_vec), .res_addr(res_addr)
  );

  // bench register file, byte addressed, little-endian
  logic [7:0] rf [256];

  always_comb begin
    case (rd_size)
      2'd0:    rd_data = {24'h0, rf[rd_code]};
      2'd1:    rd_data = {16'h0, rf[rd_code + 8'd1], rf[rd_code]};
      default: rd_data = {rf[rd_code + 8'd3], rf[rd_code + 8'd2],
                          rf[rd_code + 8'd1], rf[rd_code]};
    endcase
  end

  always @(posedge clk) begin
    if (wr_en) begin
      rf[wr_code]        <= wr_data[7:0];
      rf[wr_code + 8'd1] <= wr_data[15:8];
      rf[wr_code + 8'd2] <= wr_data[23:16];
      rf[wr_code + 8'd3] <= wr_data[31:24];
    end
  end

  function automatic logic [31:0] rdl(input logic [7:0] c);
    return {rf[c + 8'd3], rf[c + 8'd2], rf[c + 8'd1], rf[c]};
  endfunction

  function automatic logic [31:0] sx8(input logic [7:0] x);
    return {{24{x[7]}}, x};
  endfunction

  function automatic logic [31:0] sx16(input logic [15:0] x);
    return {{16{x[15]}}, x};
  endfunction

  function automatic logic [7:0] byte_reg(input logic [2:0] i);
    case (i)
      3'd0: return 8'hE1;  3'd1: return 8'hE0;
      3'd2: return 8'hE5;  3'd3: return 8'hE4;
      3'd4: return 8'hE9;  3'd5: return 8'hE8;
      3'd6: return 8'hED;  default: return 8'hEC;
    endcase
  endfunction

  function automatic logic [47:0] mk(input logic [7:0] b0, input logic [7:0] b1 = 0,
                                     input logic [7:0] b2 = 0, input logic [7:0] b3 = 0);
    return {16'h0, b3, b2, b1, b0};
  endfunction

  // expected values
  int          e_n;
  logic [2:0]  e_kind;
  logic [1:0]  e_size;
  logic [7:0]  e_reg;
  logic [2:0]  e_vec;
  logic [31:0] e_addr;
  logic        e_we;
  logic [7:0]  e_wcode;
  logic [31:0] e_wdata;
  string       e_req;

  task automatic model(input logic [47:0] s);
    logic [7:0]  b, m;
    logic [1:0]  g;
    logic [3:0]  l;
    logic [31:0] p, st;
    b = s[7:0]; m = s[15:8];
    e_n = 1; e_kind = 3'd0; e_size = 2'd3; e_reg = 0; e_vec = 0; e_addr = 0;
    e_we = 0; e_wcode = 0; e_wdata = 0; e_req = "R11";
    g = b[5:4]; l = b[3:0];
    if (b == 8'h00) e_kind = 3'd1;
    else if (b == 8'h12) e_kind = 3'd2;
    else if (b == 8'h04 || b == 8'h1F) e_kind = 3'd3;
    else if (b[7:6] == 2'b10) begin
      e_req = "R3";
      e_kind = (g == 2'd3) ? 3'd7 : 3'd6;
      e_size = g;
      p = rdl(8'hE0 + {3'b0, b[2:0], 2'b0});
      if (b[3]) begin e_addr = p + sx8(m); e_n = 2; end
      else e_addr = p;
    end else if (b[7:6] == 2'b11) begin
      if (g == 2'd3 && l >= 4'd8) begin
        e_req = "R10"; e_kind = 3'd4; e_vec = b[2:0];
      end else if (l >= 4'd8) begin
        e_req = "R9"; e_kind = 3'd5; e_size = g;
        e_reg = (g == 2'd0) ? byte_reg(b[2:0]) : 8'hE0 + {3'b0, b[2:0], 2'b0};
      end else if (l == 4'd6 || (l == 4'd7 && g == 2'd3)) begin
        e_kind = 3'd3;
      end else if (l == 4'd7) begin
        e_req = "R8"; e_kind = 3'd5; e_size = g; e_n = 2;
        e_reg = (g == 2'd2) ? (m & 8'hFC) : (g == 2'd1) ? (m & 8'hFE) : m;
      end else begin
        e_kind = (g == 2'd3) ? 3'd7 : 3'd6;
        e_size = g;
        p = rdl(m & 8'hFC);
        case (m[1:0])
          2'd0: st = 1; 2'd1: st = 2; 2'd2: st = 4; default: st = 0;
        endcase
        if (l <= 4'd2) begin
          e_req = "R4"; e_n = 2 + int'(l);
          e_addr = {24'h0, s[15:8]};
          if (l >= 4'd1) e_addr[15:8]  = s[23:16];
          if (l == 4'd2) e_addr[23:16] = s[31:24];
        end else if (l == 4'd3) begin
          e_req = "R5";
          case (m[1:0])
            2'd0: begin e_addr = p; e_n = 2; end
            2'd1: begin e_addr = p + sx16(s[31:16]); e_n = 4; end
            2'd2: begin e_addr = p + sx8(rf[s[23:16]]); e_n = 3; end
            default: begin
              e_addr = p + sx16({rf[(s[23:16] & 8'hFE) + 8'd1], rf[s[23:16] & 8'hFE]});
              e_n = 3;
            end
          endcase
        end else if (l == 4'd4) begin
          e_req = "R6"; e_n = 2; e_addr = p - st;
          e_we = (st != 0); e_wcode = m & 8'hFC; e_wdata = p - st;
        end else begin
          e_req = "R7"; e_n = 2; e_addr = p;
          e_we = (st != 0); e_wcode = m & 8'hFC; e_wdata = p + st;
        end
      end
    end
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_instr(input logic [47:0] s, input bit gaps);
    model(s);
    for (int i = 0; i < e_n; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      chk(!res_valid && in_ready, "R1", "ready before last byte",
          {30'b0, res_valid, in_ready}, 32'h1);
      in_valid = 1'b1;
      in_data  = s[8*i +: 8];
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk(res_valid == 1'b1, "R1", "result after last byte", {31'b0, res_valid}, 32'h1);
    chk(res_kind == e_kind, "R2", $sformatf("kind %s", e_req), {29'b0, res_kind}, {29'b0, e_kind});
    chk(res_size == e_size, e_req, "size", {30'b0, res_size}, {30'b0, e_size});
    chk(res_reg == e_reg, e_req, "reg", {24'b0, res_reg}, {24'b0, e_reg});
    chk(res_vec == e_vec, e_req, "vec", {29'b0, res_vec}, {29'b0, e_vec});
    chk(res_addr == e_addr, e_req, "addr", res_addr, e_addr);
    chk(wr_en == e_we, e_req, "wr_en", {31'b0, wr_en}, {31'b0, e_we});
    if (e_we) begin
      chk(wr_code == e_wcode, e_req, "wr_code", {24'b0, wr_code}, {24'b0, e_wcode});
      chk(wr_data == e_wdata, e_req, "wr_data", wr_data, e_wdata);
    end
    for (int j = 0; j < int'($urandom % 3); j++) begin
      in_valid = 1'b1;
      in_data  = 8'($urandom);
      @(negedge clk);
      chk(!in_ready && res_valid && res_addr == e_addr, "R1", "hold while pending",
          res_addr, e_addr);
    end
    in_valid = 1'b0;
    res_ack  = 1'b1;
    @(negedge clk);
    res_ack  = 1'b0;
    chk(!res_valid, "R1", "released after ack", {31'b0, res_valid}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog: actual=%h expected=%h", 32'h1, 32'h0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20190105));
    for (int i = 0; i < 256; i++) rf[i] = 8'($urandom);
    rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00; res_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(in_ready && !res_valid && !wr_en, "R1", "reset state",
        {29'b0, in_ready, res_valid, wr_en}, 32'h4);

    // directed corners
    rf[8'hF0] = 8'hFF; rf[8'hF1] = 8'hFF; rf[8'hF2] = 8'hFF; rf[8'hF3] = 8'hFF;
    run_instr(mk(8'hC5, 8'hF0), 1'b0);             // R7 wrap to zero
    run_instr(mk(8'hE4, 8'hF3), 1'b0);             // R6 step selector 3, no write
    run_instr(mk(8'hE4, 8'hF2), 1'b0);             // R6 long step
    run_instr(mk(8'h88, 8'h80), 1'b0);             // R3 disp -128
    run_instr(mk(8'hB9, 8'h7F), 1'b0);             // R3 target
    run_instr(mk(8'hD3, 8'h05, 8'h00, 8'h80), 1'b0); // R5 disp16 negative
    run_instr(mk(8'hE3, 8'h07, 8'h33), 1'b0);      // R5 word index masked
    run_instr(mk(8'hC3, 8'h12, 8'h81), 1'b0);      // R5 byte index
    run_instr(mk(8'hE2, 8'h11, 8'h22, 8'hF3), 1'b0); // R4 24-bit absolute
    run_instr(mk(8'hF0, 8'hAB), 1'b0);             // R4 8-bit absolute
    run_instr(mk(8'hE7, 8'hFF), 1'b0);             // R8 long mask
    run_instr(mk(8'hD7, 8'hFF), 1'b0);             // R8 word mask
    run_instr(mk(8'hC7, 8'hFF), 1'b0);             // R8 byte
    run_instr(mk(8'hCA), 1'b0);                    // R9
    run_instr(mk(8'hDF), 1'b0);                    // R9
    run_instr(mk(8'hEF), 1'b0);                    // R9
    run_instr(mk(8'hFF), 1'b0);                    // R10
    run_instr(mk(8'hF8), 1'b0);                    // R10
    run_instr(mk(8'hF7), 1'b0);                    // R11
    run_instr(mk(8'hC6), 1'b0);                    // R11
    run_instr(mk(8'h1F), 1'b0);                    // R11
    run_instr(mk(8'h12), 1'b0);                    // R11
    run_instr(mk(8'h00), 1'b0);                    // R11
    run_instr(mk(8'h04), 1'b0);                    // R11
    run_instr(mk(8'h7E), 1'b0);                    // R11 other

    // random traffic
    for (int k = 0; k < 600; k++) begin
      logic [47:0] s;
      s = {16'h0, 32'($urandom)};
      if ($urandom % 4 != 0) s[7] = 1'b1;
      if ($urandom % 2 == 0) s[6] = 1'b1;
      run_instr(s, 1'b1);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule